// File: doc/BRIEF.md
# 64-bit Integer Add Execution Slice with Carry, Overflow and Condition Flags

This block executes the register-to-register integer add of a 64-bit load/store architecture that uses big-endian bit numbering for its instruction fields. It takes one instruction word, the address of that instruction and the two source operand values. It checks that the word is the plain add form. It then returns the 64-bit sum, the destination register index, the fall-through address and a flag set. The flag set holds carry and signed overflow for both the full 64-bit width and the low 32-bit half, the summary-overflow bit, and the three sign bits (negative, positive, zero) that feed the condition register.

Operands are read from the caller's general-purpose register file. The block decodes the two source indices combinationally from the incoming word, so the caller can use them to index its register file in the same cycle. A transaction enters on a valid/ready handshake. Its result sits in a single output stage one cycle later and stays there until the consumer takes it. Any word that is not the supported add form still passes through and comes out marked as an error, with write-back disabled.

Top module: `padd_unit`

## Requirements
- R1: An instruction is accepted as add only when bits [31:26] equal 31, bits [9:1] equal 266, bit 10 is 0 and bit 0 is 0. For such a word, out_rt carries bits [25:21]. The word 0x7C632214 decodes as an add to register 3. rd_idx_a always shows bits [20:16] and rd_idx_b always shows bits [15:11] of in_insn.
- R2: A word that fails any of the R1 tests produces out_err=1 and out_wen=0. The same beat carries out_rt, out_result and all eight flag outputs at 0.
- R3: For an accepted add, out_result is (in_opa + in_opb) mod 2^64 and out_wen=1.
- R4: out_ca is the carry out of the unsigned 64-bit add.
- R5: out_ca32 is the carry out of the unsigned add of the two low 32-bit halves.
- R6: out_ov is 1 exactly when the true signed sum of the two 64-bit operands lies outside [-2^63, 2^63-1].
- R7: out_ov32 is 1 exactly when the true signed sum of the two low 32-bit halves lies outside [-2^31, 2^31-1].
- R8: For an accepted add, exactly one of out_lt, out_gt and out_eq is 1. Reading out_result as signed, out_lt means negative, out_gt means positive and out_eq means zero.
- R9: out_so equals out_ov of the same beat. No earlier instruction affects it.
- R10: out_next_pc equals in_pc + 4 of the same transaction, so the instruction never redirects fetch.
- R11: A transaction accepted on a rising edge (in_valid and in_ready both 1) shows out_valid=1 right after that edge.
- R12: in_ready = (!out_valid || out_ready) once the reset has been released. While out_valid=1 and out_ready=0, in_ready is 0 and every output stays unchanged.
- R13: While rst_n is low, and for the two edges after it rises, out_valid and in_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming transaction present |
| in_ready | output | 1 | Block can take a transaction this cycle |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 64 | Address of the instruction |
| in_opa | input | 64 | Value of the first source register |
| in_opb | input | 64 | Value of the second source register |
| rd_idx_a | output | 5 | First source index decoded from in_insn |
| rd_idx_b | output | 5 | Second source index decoded from in_insn |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_wen | output | 1 | Result is to be written back |
| out_err | output | 1 | Word was not the supported add form |
| out_rt | output | 5 | Destination register index |
| out_result | output | 64 | Sum |
| out_next_pc | output | 64 | Fall-through address |
| out_ca | output | 1 | 64-bit carry |
| out_ca32 | output | 1 | 32-bit carry |
| out_ov | output | 1 | 64-bit signed overflow |
| out_ov32 | output | 1 | 32-bit signed overflow |
| out_so | output | 1 | Summary overflow |
| out_lt | output | 1 | Result negative |
| out_gt | output | 1 | Result positive |
| out_eq | output | 1 | Result zero |

## Verification
The delicate cycle is the one where the output stage drains and refills on the same edge. Here out_ready takes the waiting beat while a new instruction is accepted behind it. In that cycle in_ready must stay high even though out_valid is high. The bench provokes this case by holding in_valid up continuously while out_ready toggles at random. A queue-based model pops on every drain and pushes on every acceptance at the same edge. Its front entry is compared against every output field on every cycle, so a refill that is lost or doubled shows up as a mismatch in out_valid or in the payload.

// File: rtl/padd_pkg.sv
package padd_pkg;

  localparam int XLEN_P = 64;
  localparam int ILEN_P = 32;
  localparam int RIDX_P = 5;

  localparam logic [5:0] PRIMARY_ALU = 6'd31;
  localparam logic [8:0] EXT_ADD     = 9'd266;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
    logic lt;
    logic gt;
    logic eq;
  } flags_t;

  typedef struct packed {
    logic              wen;
    logic              err;
    logic [RIDX_P-1:0] rt;
    logic [XLEN_P-1:0] result;
    logic [XLEN_P-1:0] npc;
    flags_t            flags;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);

endpackage

// File: rtl/padd_rst_sync.sv
module padd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/padd_decode.sv
module padd_decode
  import padd_pkg::*;
#(
  parameter int ILEN   = ILEN_P,
  parameter int RIDX_W = RIDX_P
) (
  input  logic [ILEN-1:0]   insn,
  output logic              is_add,
  output logic [RIDX_W-1:0] rt,
  output logic [RIDX_W-1:0] ra,
  output logic [RIDX_W-1:0] rb
);

  localparam int OPC_W  = 6;
  localparam int RT_LSB = ILEN - OPC_W - RIDX_W;
  localparam int RA_LSB = RT_LSB - RIDX_W;
  localparam int RB_LSB = RA_LSB - RIDX_W;
  localparam int OE_BIT = RB_LSB - 1;
  localparam int XO_W   = OE_BIT - 1;

  logic opc_hit;
  logic xo_hit;
  logic oe_bit;
  logic rc_bit;

  always_comb begin
    opc_hit = (insn[ILEN-1 -: OPC_W] == PRIMARY_ALU);
    xo_hit  = (insn[XO_W:1] == EXT_ADD);
    oe_bit  = insn[OE_BIT];
    rc_bit  = insn[0];
    is_add  = opc_hit && xo_hit && !oe_bit && !rc_bit;
    rt      = insn[RT_LSB +: RIDX_W];
    ra      = insn[RA_LSB +: RIDX_W];
    rb      = insn[RB_LSB +: RIDX_W];
  end

endmodule

// File: rtl/padd_flags.sv
module padd_flags
  import padd_pkg::*;
#(
  parameter int XLEN = XLEN_P
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum,
  output flags_t          flags
);

  localparam int LANES = 2;
  localparam int SEG   = XLEN / LANES;

  logic [LANES:0]   cin;
  logic [LANES-1:0] ovf_l;
  logic [SEG:0]     seg_res [LANES];

  assign cin[0] = 1'b0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEG-1:0] a_s;
    logic [SEG-1:0] b_s;
    assign a_s        = a[g*SEG +: SEG];
    assign b_s        = b[g*SEG +: SEG];
    assign seg_res[g] = {1'b0, a_s} + {1'b0, b_s} + {{SEG{1'b0}}, cin[g]};
    assign cin[g+1]   = seg_res[g][SEG];
    assign ovf_l[g]   = (a_s[SEG-1] == b_s[SEG-1]) &&
                        (seg_res[g][SEG-1] != a_s[SEG-1]);
    assign sum[g*SEG +: SEG] = seg_res[g][SEG-1:0];
  end

  always_comb begin
    flags.ca   = cin[LANES];
    flags.ca32 = cin[1];
    flags.ov   = ovf_l[LANES-1];
    flags.ov32 = ovf_l[0];
    flags.so   = ovf_l[LANES-1];
    flags.lt   = sum[XLEN-1];
    flags.eq   = ~|sum;
    flags.gt   = !sum[XLEN-1] && (|sum);
  end

endmodule

// File: rtl/padd_outreg.sv
module padd_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drop,
  input  logic [W-1:0] d,
  output logic         valid,
  output logic [W-1:0] q
);

  logic         valid_q;
  logic         valid_d;
  logic [W-1:0] data_q;
  logic [W-1:0] data_d;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (load) begin
      valid_d = 1'b1;
      data_d  = d;
    end else if (drop) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) data_q <= data_d;
    end
  end

  assign valid = valid_q;
  assign q     = data_q;

endmodule

// File: rtl/padd_unit.sv
module padd_unit
  import padd_pkg::*;
#(
  parameter int XLEN   = XLEN_P,
  parameter int ILEN   = ILEN_P,
  parameter int RIDX_W = RIDX_P
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ILEN-1:0]   in_insn,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [XLEN-1:0]   in_opa,
  input  logic [XLEN-1:0]   in_opb,
  output logic [RIDX_W-1:0] rd_idx_a,
  output logic [RIDX_W-1:0] rd_idx_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wen,
  output logic              out_err,
  output logic [RIDX_W-1:0] out_rt,
  output logic [XLEN-1:0]   out_result,
  output logic [XLEN-1:0]   out_next_pc,
  output logic              out_ca,
  output logic              out_ca32,
  output logic              out_ov,
  output logic              out_ov32,
  output logic              out_so,
  output logic              out_lt,
  output logic              out_gt,
  output logic              out_eq
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(ILEN / 8);

  logic              rst_q;
  logic              dec_add;
  logic [RIDX_W-1:0] dec_rt;
  logic [XLEN-1:0]   sum;
  flags_t            fl;
  beat_t             beat_d;
  beat_t             beat_q;
  logic [BEAT_W-1:0] beat_vec_q;
  logic              accept;
  logic              drain;

  padd_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  padd_decode #(.ILEN(ILEN), .RIDX_W(RIDX_W)) u_dec (
    .insn   (in_insn),
    .is_add (dec_add),
    .rt     (dec_rt),
    .ra     (rd_idx_a),
    .rb     (rd_idx_b)
  );

  padd_flags #(.XLEN(XLEN)) u_flags (
    .a     (in_opa),
    .b     (in_opb),
    .sum   (sum),
    .flags (fl)
  );

  always_comb begin
    in_ready = rst_q && (!out_valid || out_ready);
    accept   = in_valid && in_ready;
    drain    = out_valid && out_ready;

    beat_d.wen    = dec_add;
    beat_d.err    = !dec_add;
    beat_d.rt     = dec_add ? dec_rt : '0;
    beat_d.result = dec_add ? sum    : '0;
    beat_d.npc    = in_pc + INSN_BYTES;
    beat_d.flags  = dec_add ? fl     : '0;
  end

  padd_outreg #(.W(BEAT_W)) u_out (
    .clk   (clk),
    .rst_n (rst_q),
    .load  (accept),
    .drop  (drain),
    .d     (beat_d),
    .valid (out_valid),
    .q     (beat_vec_q)
  );

  always_comb begin
    beat_q      = beat_t'(beat_vec_q);
    out_wen     = beat_q.wen;
    out_err     = beat_q.err;
    out_rt      = beat_q.rt;
    out_result  = beat_q.result;
    out_next_pc = beat_q.npc;
    out_ca      = beat_q.flags.ca;
    out_ca32    = beat_q.flags.ca32;
    out_ov      = beat_q.flags.ov;
    out_ov32    = beat_q.flags.ov32;
    out_so      = beat_q.flags.so;
    out_lt      = beat_q.flags.lt;
    out_gt      = beat_q.flags.gt;
    out_eq      = beat_q.flags.eq;
  end

  AST_SIGN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_wen) |-> $onehot({out_lt, out_gt, out_eq})); // R8

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_err) |-> (!out_wen && out_result == '0 &&
      {out_ca, out_ca32, out_ov, out_ov32, out_so, out_lt, out_gt, out_eq} == '0)); // R2

  AST_SO_TRACKS_OV: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (out_so == out_ov)); // R9

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_ready) |=> out_valid); // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_rt) && $stable(out_next_pc))); // R12

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_ready) |-> !in_ready); // R12

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_q |-> (!out_valid && !in_ready)); // R13

endmodule

// File: tb/padd_unit_tb.sv
module padd_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_insn;
  logic [63:0] in_pc;
  logic [63:0] in_opa;
  logic [63:0] in_opb;
  logic [4:0]  rd_idx_a;
  logic [4:0]  rd_idx_b;
  logic        out_valid;
  logic        out_ready;
  logic        out_wen;
  logic        out_err;
  logic [4:0]  out_rt;
  logic [63:0] out_result;
  logic [63:0] out_next_pc;
  logic        out_ca, out_ca32, out_ov, out_ov32, out_so, out_lt, out_gt, out_eq;

  always #2 clk = ~clk;

  padd_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn), .in_pc(in_pc),
    .in_opa(in_opa), .in_opb(in_opb), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_wen(out_wen), .out_err(out_err),
    .out_rt(out_rt), .out_result(out_result), .out_next_pc(out_next_pc),
    .out_ca(out_ca), .out_ca32(out_ca32), .out_ov(out_ov), .out_ov32(out_ov32),
    .out_so(out_so), .out_lt(out_lt), .out_gt(out_gt), .out_eq(out_eq)
  );

  typedef struct {
    bit        wen;
    bit        err;
    bit [4:0]  rt;
    bit [63:0] res;
    bit [63:0] npc;
    bit        ca, ca32, ov, ov32, so, lt, gt, eq;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   warm    = 1'b0;
  bit   taken   = 1'b0;
  bit   done    = 1'b0;

  localparam int N_DIRECTED = 12;
  localparam int N_RANDOM   = 600;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] t, input logic [4:0] a,
                                     input logic [4:0] b, input logic oe,
                                     input logic [8:0] xo, input logic rc);
    return {6'd31, t, a, b, oe, xo, rc};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] pc,
                                 input logic [63:0] a, input logic [63:0] b);
    exp_t e;
    logic [64:0]        u64;
    logic [32:0]        u32;
    logic signed [64:0] s64;
    logic signed [32:0] s32;
    bit ok;
    ok = (w[31:26] == 6'd31) && (w[9:1] == 9'd266) && !w[10] && !w[0];
    u64 = {1'b0, a} + {1'b0, b};
    u32 = {1'b0, a[31:0]} + {1'b0, b[31:0]};
    s64 = $signed({a[63], a}) + $signed({b[63], b});
    s32 = $signed({a[31], a[31:0]}) + $signed({b[31], b[31:0]});
    e = '{default: 0};
    e.npc = pc + 64'd4;
    e.wen = ok;
    e.err = !ok;
    if (ok) begin
      e.rt   = w[25:21];
      e.res  = u64[63:0];
      e.ca   = u64[64];
      e.ca32 = u32[32];
      e.ov   = (s64[64] != s64[63]);
      e.ov32 = (s32[32] != s32[31]);
      e.so   = e.ov;
      e.lt   = $signed(u64[63:0]) < 0;
      e.gt   = $signed(u64[63:0]) > 0;
      e.eq   = (u64[63:0] == 64'd0);
    end
    return e;
  endfunction

  // Reference model: pop on drain, push on acceptance, same edge
  always @(posedge clk) begin
    if (warm) begin
      bit rdy;
      rdy = (q.size() == 0) || out_ready;
      if (q.size() > 0 && out_ready) void'(q.pop_front());
      if (in_valid && rdy) begin
        q.push_back(model(in_insn, in_pc, in_opa, in_opb));
        taken = 1'b1;
      end
    end
  end

  task automatic compare_outputs();
    chk("R11 out_valid", {63'd0, out_valid}, {63'd0, q.size() != 0});
    if (out_valid && q.size() != 0) begin
      exp_t e;
      e = q[0];
      chk("R1/R2 out_rt", {59'd0, out_rt}, {59'd0, e.rt});
      chk("R2 out_err", {63'd0, out_err}, {63'd0, e.err});
      chk("R3 out_wen", {63'd0, out_wen}, {63'd0, e.wen});
      chk("R3 out_result", out_result, e.res);
      chk("R4 out_ca", {63'd0, out_ca}, {63'd0, e.ca});
      chk("R5 out_ca32", {63'd0, out_ca32}, {63'd0, e.ca32});
      chk("R6 out_ov", {63'd0, out_ov}, {63'd0, e.ov});
      chk("R7 out_ov32", {63'd0, out_ov32}, {63'd0, e.ov32});
      chk("R8 lt/gt/eq", {61'd0, out_lt, out_gt, out_eq}, {61'd0, e.lt, e.gt, e.eq});
      chk("R9 out_so", {63'd0, out_so}, {63'd0, e.so});
      chk("R10 out_next_pc", out_next_pc, e.npc);
    end
  endtask

  task automatic pick(input int idx);
    logic [63:0] a, b;
    logic [31:0] w;
    a = 64'd0; b = 64'd0; w = 32'h7C632214;
    case (idx)
      0:  begin a = 64'h1234; b = 64'h2345; end
      1:  begin a = '1; b = 64'd1; end
      2:  begin a = 64'h7FFF_FFFF_FFFF_FFFF; b = 64'd1; end
      3:  begin a = 64'h8000_0000_0000_0000; b = 64'h8000_0000_0000_0000; end
      4:  begin a = 64'h7FFF_FFFF; b = 64'd1; end
      5:  begin a = 64'hFFFF_FFFF; b = 64'd1; end
      6:  begin a = 64'hFFFF_FFFF_FFFF_FFFE; b = 64'd0; end
      7:  begin w = 32'h7C632215; a = 64'd5; b = 64'd6; end
      8:  begin w = 32'h7C632614; a = 64'd5; b = 64'd6; end
      9:  begin w = 32'h78632214; a = 64'd5; b = 64'd6; end
      10: begin w = 32'h7C632216; a = 64'd5; b = 64'd6; end
      11: begin w = mk(5'd5, 5'd6, 5'd7, 1'b0, 9'd266, 1'b0);
                a = 64'hDEAD_BEEF_0000_0001; b = 64'h2152_4110_FFFF_FFFF; end
      default: begin
        w = mk(5'($urandom), 5'($urandom), 5'($urandom), 1'b0, 9'd266, 1'b0);
        if ($urandom_range(0, 3) == 0) begin
          int sel;
          sel = $urandom_range(0, 2);
          if (sel == 0)      w[$urandom_range(26, 31)] ^= 1'b1;
          else if (sel == 1) w[$urandom_range(0, 10)]  ^= 1'b1;
          else               w[9:1] = 9'($urandom);
        end
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        case ($urandom_range(0, 5))
          0: b = -a;
          1: begin a[63] = 1'b0; b[63] = 1'b0; a[62] = 1'b1; b[62] = 1'b1; end
          2: begin a[31:0] = 32'h7FFF_FFFF; end
          default: ;
        endcase
      end
    endcase
    in_insn = w;
    in_opa  = a;
    in_opb  = b;
    in_pc   = {$urandom, $urandom[31:2], 2'b00};
  endtask

  initial begin
    int sent;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_insn   = '0;
    in_pc     = '0;
    in_opa    = '0;
    in_opb    = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R13 in_ready in reset", {63'd0, in_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 in_ready first edge", {63'd0, in_ready}, 64'd0);
    repeat (4) @(negedge clk);
    chk("R13 out_valid after release", {63'd0, out_valid}, 64'd0);
    warm = 1'b1;
    sent = 0;
    while (sent < N_DIRECTED + N_RANDOM || q.size() != 0 || in_valid) begin
      @(negedge clk);
      compare_outputs();
      if (taken) begin
        taken = 1'b0;
        in_valid = 1'b0;
      end
      if (!in_valid && sent < N_DIRECTED + N_RANDOM &&
          (sent < N_DIRECTED || $urandom_range(0, 4) != 0)) begin
        pick(sent);
        in_valid = 1'b1;
        sent++;
      end
      out_ready = (sent <= N_DIRECTED) ? 1'b1 : ($urandom_range(0, 9) < 6);
      #1;
      chk("R12 in_ready", {63'd0, in_ready}, {63'd0, (q.size() == 0) || out_ready});
      chk("R1 rd_idx_a", {59'd0, rd_idx_a}, {59'd0, in_insn[20:16]});
      chk("R1 rd_idx_b", {59'd0, rd_idx_b}, {59'd0, in_insn[15:11]});
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule